// File: doc/BRIEF.md
# Clock Source Control Register

This block holds the 8-bit control and status word that steers the system clock. Software uses it to choose between the internal RC oscillator and the crystal, to request stop mode, to pick the clock-divide ratio and to turn power management on. Some bits change without a write. A move to the crystal waits until the crystal is ready. A move back to the RC source waits until the RC oscillator has run for a settle window. Power management drops out by itself when switchback is armed and one of four peripheral events arrives.

There are two reset domains. Power-on reset sets the whole word. Any other reset sets only the low five bits, so the chosen clock source survives a warm reset. Both resets assert asynchronously and are released synchronously inside the block. Readback is returned while the read strobe is high. Writes land on the rising clock edge at which the write strobe is high.

Top module: `clk_src_ctl`

## Requirements
- R1: While `rd_en` is 1, `rdata` is {bit7 crystal select, bit6 always 0, bit5 RC-mode status, bit4 stop, bit3 switchback enable, bit2 power-management enable, bits1:0 divide select}. While `rd_en` is 0, `rdata` is 0.
- R2: After power-on reset, the word reads 8'h21: crystal select 0, RC-mode 1, divide 01, all other bits 0.
- R3: A non-power-on reset (`rst_n` low while `por_n` stays high) loads bits 4:0 with 00001b and leaves bits 7 and 5 unchanged.
- R4: A write loads bits 7 and 4:0 from `wdata`. Write data on bits 6 and 5 has no effect.
- R5: After crystal select is written to 1, RC-mode stays 1 and `clk_sel_xtal` stays 0 until `xtal_en` and `xtal_rdy` are both 1. At the first clock edge where both are 1, RC-mode clears and `clk_sel_xtal` rises.
- R6: After crystal select is written to 0, RC-mode rises at the fourth consecutive clock edge at which `rc_en` is 1. If `rc_en` has already been high that long, RC-mode rises at the next edge.
- R7: `clk_sel_xtal` is the inverse of RC-mode. `stop_req`, `pm_en` and `clk_div` follow bits 4, 2 and 1:0.
- R8: Writing stop to 1 raises `stop_req` and leaves divide and power-management bits unchanged. An `ext_irq` pulse clears stop, and this clear wins over a write in the same cycle.
- R9: With switchback and power management both 1, power management clears at the next edge on any one of: `ext_irq`; `uart_rx_fall` with `uart_rx_en`; `uart_tx_wr` with `uart_tx_en`; `spi_wr` with both `spi_master` and `spi_tx_en`. The same event with its qualifier low has no effect.
- R10: If switchback is 0 or power management is 0, none of the events changes power management.
- R11: When a write of power management = 1 and a switchback clear event fall in the same cycle, power management ends as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | Any other reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| xtal_en | input | 1 | Crystal oscillator enabled |
| xtal_rdy | input | 1 | Crystal warm-up complete |
| rc_en | input | 1 | RC oscillator enabled |
| ext_irq | input | 1 | Enabled external interrupt event |
| uart_rx_fall | input | 1 | Falling edge seen on UART receive line |
| uart_rx_en | input | 1 | UART reception enabled |
| uart_tx_wr | input | 1 | UART transmit buffer written |
| uart_tx_en | input | 1 | UART transmission enabled |
| spi_wr | input | 1 | SPI data register written |
| spi_master | input | 1 | SPI in master mode |
| spi_tx_en | input | 1 | SPI transmission enabled |
| rdata | output | 8 | Register readback |
| clk_sel_xtal | output | 1 | 1 selects the crystal, 0 the RC oscillator |
| stop_req | output | 1 | Stop mode request |
| pm_en | output | 1 | Power-management enable |
| clk_div | output | 2 | Clock-divide select |

## Verification
Most internal faults appear on `rdata` or on the clock-select pin at the first edge after the stimulus that exposes them. A source-switch state machine that moves too early shows `clk_sel_xtal` high while the crystal is still unready. A stuck settle counter delays RC-mode past the fourth qualified edge. A reset routed to the wrong domain shows a wrong bit 7 or bit 5 right after a warm reset. A broken event qualifier leaves bit 2 standing, or clears it, one edge after the pulse.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  localparam int REG_W    = 8;
  localparam int DIV_W    = 2;
  localparam int LOW_W    = 5;
  localparam int BIT_XT   = 7;
  localparam int BIT_RSV  = 6;
  localparam int BIT_RC   = 5;
  localparam int N_SBK_EV = 4;

  // low field of the word: bit4 stop, bit3 switchback, bit2 power mgmt, bits1:0 divide
  typedef struct packed {
    logic             stop;
    logic             swb;
    logic             pm;
    logic [DIV_W-1:0] div;
  } low_bits_t;

  localparam low_bits_t LOW_RST = '{stop: 1'b0, swb: 1'b0, pm: 1'b0, div: 2'b01};
endpackage

// File: rtl/clk_src_rst_sync.sv
module clk_src_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch #(
  parameter int RC_SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic wr_xt,
  input  logic wr_xt_val,
  input  logic xtal_en,
  input  logic xtal_rdy,
  input  logic rc_en,
  output logic xt_sel,
  output logic rc_mode
);
  localparam int              CNT_W   = $clog2(RC_SETTLE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RC_SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             xt_q, xt_d, rc_q, rc_d;
  logic             cnt_upd, xt_upd, rc_upd;
  logic             rc_ok, xtal_ok;

  assign rc_ok   = rc_en && (cnt_q == CNT_MAX);
  assign xtal_ok = xtal_en && xtal_rdy;

  always_comb begin
    cnt_d   = cnt_q;
    cnt_upd = 1'b0;
    if (!rc_en) begin
      cnt_d   = '0;
      cnt_upd = (cnt_q != '0);
    end else if (cnt_q != CNT_MAX) begin
      cnt_d   = cnt_q + 1'b1;
      cnt_upd = 1'b1;
    end
  end

  always_comb begin
    xt_d   = wr_xt_val;
    xt_upd = wr_xt;
  end

  always_comb begin
    rc_d   = rc_q;
    rc_upd = 1'b0;
    if (xt_q && rc_q && xtal_ok) begin
      rc_d   = 1'b0;
      rc_upd = 1'b1;
    end else if (!xt_q && !rc_q && rc_ok) begin
      rc_d   = 1'b1;
      rc_upd = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
      xt_q  <= 1'b0;
      rc_q  <= 1'b1;
    end else begin
      if (cnt_upd) cnt_q <= cnt_d;
      if (xt_upd)  xt_q  <= xt_d;
      if (rc_upd)  rc_q  <= rc_d;
    end
  end

  assign xt_sel  = xt_q;
  assign rc_mode = rc_q;
endmodule

// File: rtl/clk_src_sbk.sv
module clk_src_sbk
  import clk_src_pkg::*;
(
  input  logic swb,
  input  logic pm,
  input  logic ext_irq,
  input  logic uart_rx_fall,
  input  logic uart_rx_en,
  input  logic uart_tx_wr,
  input  logic uart_tx_en,
  input  logic spi_wr,
  input  logic spi_master,
  input  logic spi_tx_en,
  output logic sbk_clr
);
  logic [N_SBK_EV-1:0] ev_raw, ev_qual, ev_hit;

  assign ev_raw  = {spi_wr, uart_tx_wr, uart_rx_fall, ext_irq};
  assign ev_qual = {spi_master & spi_tx_en, uart_tx_en, uart_rx_en, 1'b1};

  for (genvar g = 0; g < N_SBK_EV; g++) begin : g_ev
    assign ev_hit[g] = ev_raw[g] & ev_qual[g];
  end

  assign sbk_clr = swb & pm & (|ev_hit);
endmodule

// File: rtl/clk_src_low.sv
module clk_src_low
  import clk_src_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [LOW_W-1:0] wdata,
  input  logic            ext_irq,
  input  logic            sbk_clr,
  output low_bits_t       q
);
  low_bits_t q_r, d;
  logic      upd;

  always_comb begin
    d = q_r;
    if (wr)      d = low_bits_t'(wdata);
    if (ext_irq) d.stop = 1'b0;
    if (sbk_clr) d.pm   = 1'b0;
    upd = wr | ext_irq | sbk_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= LOW_RST;
    end else if (upd) begin
      q_r <= d;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/clk_src_ctl.sv
module clk_src_ctl
  import clk_src_pkg::*;
#(
  parameter int RC_SETTLE_CYCLES = 4,
  parameter int SYNC_STAGES      = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             xtal_en,
  input  logic             xtal_rdy,
  input  logic             rc_en,
  input  logic             ext_irq,
  input  logic             uart_rx_fall,
  input  logic             uart_rx_en,
  input  logic             uart_tx_wr,
  input  logic             uart_tx_en,
  input  logic             spi_wr,
  input  logic             spi_master,
  input  logic             spi_tx_en,
  output logic [REG_W-1:0] rdata,
  output logic             clk_sel_xtal,
  output logic             stop_req,
  output logic             pm_en,
  output logic [DIV_W-1:0] clk_div
);
  logic      por_q_n, rst_all_q_n, rst_all_n;
  logic      xt_sel_q, rc_mode_q, sbk_clr;
  low_bits_t low_q;

  assign rst_all_n = por_n & rst_n;

  clk_src_rst_sync #(.STAGES(SYNC_STAGES)) i_por_sync (
    .clk(clk), .arst_n(por_n), .srst_n(por_q_n)
  );

  clk_src_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk(clk), .arst_n(rst_all_n), .srst_n(rst_all_q_n)
  );

  clk_src_switch #(.RC_SETTLE_CYCLES(RC_SETTLE_CYCLES)) i_switch (
    .clk       (clk),
    .por_n     (por_q_n),
    .wr_xt     (wr_en & rst_all_q_n),
    .wr_xt_val (wdata[BIT_XT]),
    .xtal_en   (xtal_en),
    .xtal_rdy  (xtal_rdy),
    .rc_en     (rc_en),
    .xt_sel    (xt_sel_q),
    .rc_mode   (rc_mode_q)
  );

  clk_src_sbk i_sbk (
    .swb          (low_q.swb),
    .pm           (low_q.pm),
    .ext_irq      (ext_irq),
    .uart_rx_fall (uart_rx_fall),
    .uart_rx_en   (uart_rx_en),
    .uart_tx_wr   (uart_tx_wr),
    .uart_tx_en   (uart_tx_en),
    .spi_wr       (spi_wr),
    .spi_master   (spi_master),
    .spi_tx_en    (spi_tx_en),
    .sbk_clr      (sbk_clr)
  );

  clk_src_low i_low (
    .clk     (clk),
    .rst_n   (rst_all_q_n),
    .wr      (wr_en),
    .wdata   (wdata[LOW_W-1:0]),
    .ext_irq (ext_irq),
    .sbk_clr (sbk_clr),
    .q       (low_q)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      rdata[BIT_XT]      = xt_sel_q;
      rdata[BIT_RSV]     = 1'b0;
      rdata[BIT_RC]      = rc_mode_q;
      rdata[LOW_W-1:0]   = low_q;
    end
  end

  assign clk_sel_xtal = ~rc_mode_q;
  assign stop_req     = low_q.stop;
  assign pm_en        = low_q.pm;
  assign clk_div      = low_q.div;
endmodule

// File: rtl/clk_src_ctl_chk.sv
module clk_src_ctl_chk (
  input logic       clk,
  input logic       rst_all_q_n,
  input logic       rd_en,
  input logic       wr_en,
  input logic [7:0] rdata,
  input logic       xt_sel,
  input logic       rc_mode,
  input logic       swb,
  input logic       pm_en,
  input logic       stop_req,
  input logic       xtal_en,
  input logic       xtal_rdy,
  input logic       rc_en,
  input logic       ext_irq,
  input logic       uart_rx_fall,
  input logic       uart_rx_en,
  input logic       uart_tx_wr,
  input logic       uart_tx_en,
  input logic       spi_wr,
  input logic       spi_master,
  input logic       spi_tx_en
);
  logic ev_any;
  assign ev_any = ext_irq | (uart_rx_fall & uart_rx_en) | (uart_tx_wr & uart_tx_en)
                | (spi_wr & spi_master & spi_tx_en);

  p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rst_all_q_n)
    rdata[6] == 1'b0);

  p_xtal_gate_r5: assert property (@(posedge clk) disable iff (!rst_all_q_n)
    $fell(rc_mode) |-> $past(xtal_en && xtal_rdy && xt_sel));

  p_rc_settle_r6: assert property (@(posedge clk) disable iff (!rst_all_q_n)
    $rose(rc_mode) |-> $past(rc_en && !xt_sel));

  p_stop_irq_r8: assert property (@(posedge clk) disable iff (!rst_all_q_n)
    ext_irq |=> !stop_req);

  p_sbk_clear_r9: assert property (@(posedge clk) disable iff (!rst_all_q_n)
    (swb && pm_en && ev_any) |=> !pm_en);

  p_pm_hold_r10: assert property (@(posedge clk) disable iff (!rst_all_q_n)
    (!swb && !wr_en) |=> $stable(pm_en));
endmodule

bind clk_src_ctl clk_src_ctl_chk i_chk (
  .clk          (clk),
  .rst_all_q_n  (rst_all_q_n),
  .rd_en        (rd_en),
  .wr_en        (wr_en),
  .rdata        (rdata),
  .xt_sel       (xt_sel_q),
  .rc_mode      (rc_mode_q),
  .swb          (low_q.swb),
  .pm_en        (pm_en),
  .stop_req     (stop_req),
  .xtal_en      (xtal_en),
  .xtal_rdy     (xtal_rdy),
  .rc_en        (rc_en),
  .ext_irq      (ext_irq),
  .uart_rx_fall (uart_rx_fall),
  .uart_rx_en   (uart_rx_en),
  .uart_tx_wr   (uart_tx_wr),
  .uart_tx_en   (uart_tx_en),
  .spi_wr       (spi_wr),
  .spi_master   (spi_master),
  .spi_tx_en    (spi_tx_en)
);

// File: tb/test_clk_src_ctl.sv
module test_clk_src_ctl;
  logic clk = 1'b0;
  logic por_n, rst_n, wr_en, rd_en, xtal_en, xtal_rdy, rc_en;
  logic ext_irq, uart_rx_fall, uart_rx_en, uart_tx_wr, uart_tx_en;
  logic spi_wr, spi_master, spi_tx_en;
  logic [7:0] wdata, rdata;
  logic clk_sel_xtal, stop_req, pm_en;
  logic [1:0] clk_div;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clk_src_ctl i_clk_src_ctl (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .xtal_en(xtal_en), .xtal_rdy(xtal_rdy), .rc_en(rc_en),
    .ext_irq(ext_irq), .uart_rx_fall(uart_rx_fall), .uart_rx_en(uart_rx_en),
    .uart_tx_wr(uart_tx_wr), .uart_tx_en(uart_tx_en), .spi_wr(spi_wr),
    .spi_master(spi_master), .spi_tx_en(spi_tx_en), .rdata(rdata),
    .clk_sel_xtal(clk_sel_xtal), .stop_req(stop_req), .pm_en(pm_en),
    .clk_div(clk_div)
  );

  // write data, expected readback (bit5 stays 1, bit6 reads 0)
  localparam logic [15:0] VEC [8] = '{
    {8'h00, 8'h20}, {8'h7F, 8'h3F}, {8'h40, 8'h20}, {8'h0A, 8'h2A},
    {8'h15, 8'h35}, {8'h5E, 8'h3E}, {8'h03, 8'h23}, {8'h1C, 8'h3C}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // k: 0 ext irq, 1 uart rx, 2 uart tx, 3 spi; q: qualifier
  task automatic ev(input int k, input bit q);
    @(negedge clk);
    case (k)
      0: ext_irq = 1'b1;
      1: begin uart_rx_fall = 1'b1; uart_rx_en = q; end
      2: begin uart_tx_wr = 1'b1; uart_tx_en = q; end
      default: begin spi_wr = 1'b1; spi_master = 1'b1; spi_tx_en = q; end
    endcase
    @(negedge clk);
    {ext_irq, uart_rx_fall, uart_rx_en, uart_tx_wr, uart_tx_en} = '0;
    {spi_wr, spi_master, spi_tx_en} = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b1; wr_en = 1'b0; rd_en = 1'b1; wdata = '0;
    xtal_en = 1'b0; xtal_rdy = 1'b0; rc_en = 1'b0;
    {ext_irq, uart_rx_fall, uart_rx_en, uart_tx_wr, uart_tx_en} = '0;
    {spi_wr, spi_master, spi_tx_en} = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 por word", rdata, 8'h21);
    chk("R7 clk_sel after por", {7'd0, clk_sel_xtal}, 8'h00);
    chk("R7 clk_div after por", {6'd0, clk_div}, 8'h01);
    rd_en = 1'b0; #1;
    chk("R1 rd_en low", rdata, 8'h00);
    rd_en = 1'b1;

    rc_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][15:8]);
      chk("R4 write mask", rdata, VEC[i][7:0]);
    end
    wr(8'h01);

    // R5 pending crystal switch
    @(negedge clk); rc_en = 1'b0; xtal_en = 1'b1; xtal_rdy = 1'b0;
    wr(8'h81);
    chk("R5 pending word", rdata, 8'hA1);
    repeat (3) @(negedge clk);
    chk("R5 still pending", rdata, 8'hA1);
    chk("R5 clk_sel pending", {7'd0, clk_sel_xtal}, 8'h00);
    xtal_rdy = 1'b1;
    @(negedge clk);
    chk("R5 switched word", rdata, 8'h81);
    chk("R7 clk_sel crystal", {7'd0, clk_sel_xtal}, 8'h01);

    // R3 warm reset keeps bits 7 and 5
    wr(8'h9C);
    chk("R3 before warm reset", rdata, 8'h9C);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R3 during warm reset", rdata, 8'h81);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 after warm reset", rdata, 8'h81);
    chk("R3 clk_sel kept", {7'd0, clk_sel_xtal}, 8'h01);

    // R6 return to RC after settle window
    wr(8'h01);
    chk("R6 waiting for rc", rdata, 8'h01);
    rc_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 three edges", rdata, 8'h01);
    @(negedge clk);
    chk("R6 fourth edge", rdata, 8'h21);
    chk("R7 clk_sel rc", {7'd0, clk_sel_xtal}, 8'h00);

    // R2 por from crystal state
    wr(8'h85);
    @(negedge clk);
    chk("R2 crystal before por", rdata, 8'h85);
    por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 por again", rdata, 8'h21);

    // R8 stop
    wr(8'h16);
    chk("R8 stop set", rdata, 8'h36);
    chk("R7 stop_req", {7'd0, stop_req}, 8'h01);
    chk("R7 clk_div", {6'd0, clk_div}, 8'h02);
    ev(0, 1'b1);
    chk("R8 irq clears stop", rdata, 8'h26);
    @(negedge clk); wr_en = 1'b1; wdata = 8'h16; ext_irq = 1'b1;
    @(negedge clk); wr_en = 1'b0; ext_irq = 1'b0;
    chk("R8 irq beats write", rdata, 8'h26);

    // R9 each trigger
    for (int k = 0; k < 4; k++) begin
      wr(8'h0D);
      if (k != 0) begin
        ev(k, 1'b0);
        chk("R9 unqualified event", rdata, 8'h2D);
      end
      ev(k, 1'b1);
      chk("R9 qualified event", rdata, 8'h29);
      chk("R7 pm_en cleared", {7'd0, pm_en}, 8'h00);
    end

    // R10 switchback off or pm off
    wr(8'h05);
    for (int k = 0; k < 4; k++) ev(k, 1'b1);
    chk("R10 swb off", rdata, 8'h25);
    wr(8'h09);
    for (int k = 0; k < 4; k++) ev(k, 1'b1);
    chk("R10 pm off", rdata, 8'h29);

    // R11 clear beats write
    wr(8'h0D);
    @(negedge clk); wr_en = 1'b1; wdata = 8'h0D; uart_tx_wr = 1'b1; uart_tx_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; uart_tx_wr = 1'b0; uart_tx_en = 1'b0;
    chk("R11 clear beats write", rdata, 8'h29);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule